// File: doc/BRIEF.md
# Cluster Power-Up Sequencer

This block takes a processor cluster from fully off to running after a single start request. It has a fixed order of steps. First it releases the cluster reset and sets up isolation. Then it powers the PLL and removes the PLL output isolation after a delay. Next it releases the clock sources, loads the clock dividers, fires a clock-change trigger and turns on the functional clocks. Last, it releases the bus, peripheral and L2 soft resets, in that order.

Each step drives one output bit per cluster. The timed waits come from one shared cycle counter, and the parameter `CYC_PER_US` scales them. The block keeps one power-state bit per cluster. Cluster 0 is always on, and a cluster is marked on as soon as its request is accepted. A request for a cluster that is already on, or that arrives while a sequence runs, is dropped. A request for an index that cannot be powered is rejected with an error pulse.

In the timing below, C stands for `CYC_PER_US`. The clock edge that samples an accepted request is counted as k = 0. An output "at k" is the value seen after edge k.

Top module: `clus_pwr_seq`

## Requirements
- R1: After reset, `clus_on` is 0001. `busy`, `done` and `err` are low. Every off cluster (1 to N-1) has `clus_io_iso` and `core_io_iso` high and all its other per-cluster outputs low. Cluster 0 always shows its running values: all resets released, clocks and PLL on, `clus_io_iso`, `core_io_iso`, `pll_out_iso`, `div_load` and `clk_trig` low, and `dft_iso`, `mem_iso` and `core_mem_iso` high.
- R2: While the block is idle, a request with `req_idx` in 1..N-1 for a cluster that is off is accepted. At k=0, `busy` is high and that cluster's `clus_on` bit is set.
- R3: At k=1, `rst_rel` is high. At k=2, `clus_io_iso` is low while `dft_iso` and `mem_iso` are high. At k=3, `core_io_iso` is low and `core_mem_iso` is high.
- R4: At k=4, `pll_ldo_en`, `pll_en` and `pll_out_iso` all go high together. `pll_out_iso` drops at k=5+2C, which is at least 2 microseconds later. Both PLL enables stay high.
- R5: `clksrc_rst_rel` rises at k=6+3C, one microsecond plus one cycle after the PLL output isolation drops.
- R6: `div_load` is a one-cycle pulse at k=7+4C. `clk_trig` is a one-cycle pulse at k=8+4C. `func_clk_en` rises at k=9+4C.
- R7: The soft resets are released in a fixed order: `bus_rst_rel` at k=10+4C, `periph_rst_rel` at k=11+4C and `l2_rst_rel` at k=12+4C.
- R8: `done` is high for exactly one cycle, at k=12+4C. `busy` is high from k=0 through k=11+4C and low at k=12+4C.
- R9: A request that arrives while `busy` is high changes nothing. No `clus_on` bit is set, no outputs move, and the running sequence completes on its original timing.
- R10: A request for a cluster whose `clus_on` bit is already set gives `done` at k=0, with `err` and `busy` low. No output changes.
- R11: A request for index 0, or for any index of N or above, gives `done` and `err` together for one cycle at k=0. No other output changes.
- R12: A sequence changes only the outputs of the cluster it addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Power-on request strobe |
| req_idx | input | IDX_W | Cluster index of the request |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle invalid-index pulse, with done |
| clus_on | output | N_CLUS | Remembered power state per cluster |
| rst_rel | output | N_CLUS | Cluster-level reset released |
| clus_io_iso | output | N_CLUS | Cluster I/O isolation |
| dft_iso | output | N_CLUS | Cluster DFT isolation |
| mem_iso | output | N_CLUS | Cluster memory isolation |
| core_io_iso | output | N_CLUS | I/O isolation of both cores |
| core_mem_iso | output | N_CLUS | Memory isolation of both cores |
| pll_ldo_en | output | N_CLUS | PLL regulator enable |
| pll_en | output | N_CLUS | PLL enable |
| pll_out_iso | output | N_CLUS | PLL output isolation |
| clksrc_rst_rel | output | N_CLUS | Crystal and PLL soft resets released |
| div_load | output | N_CLUS | One-cycle pulse that loads the clock dividers |
| clk_trig | output | N_CLUS | One-cycle clock-change trigger |
| func_clk_en | output | N_CLUS | Functional clock enables |
| bus_rst_rel | output | N_CLUS | Bus clock-domain soft resets released |
| periph_rst_rel | output | N_CLUS | Temperature-monitor soft reset released |
| l2_rst_rel | output | N_CLUS | L2 cache soft reset released |

## Verification
The bench records, for every output bit of the addressed cluster, the exact cycle of each change and compares it with the k offsets above. Off-by-one waits, a swapped reset order or a late PLL de-isolation therefore show up as a wrong edge time, and a stretched trigger shows up as a second missing edge. A request injected in the middle of a sequence must leave the other cluster off. A design that queued it, or marked that cluster on, would show a changed `clus_on` bit or a stray `done`. Repeated requests and requests for index 0 or an out-of-range index must return a one-cycle response at k=0 and disturb no output. A design that restarted the sequence or failed to flag the bad index would show `busy` rising or the wrong `err` value.

// File: rtl/pwrseq_pkg.sv
// Package: step encoding shared by the sequencer control and the per-cluster banks.
// Assumes the state order below is the power-up order; the banks decode it.
package pwrseq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE       = 4'd0,
        ST_RST        = 4'd1,
        ST_ISO_CLUS   = 4'd2,
        ST_ISO_CORE   = 4'd3,
        ST_PLL_ON     = 4'd4,
        ST_PLL_WAIT   = 4'd5,
        ST_PLL_DEISO  = 4'd6,
        ST_CFG_WAIT   = 4'd7,
        ST_CLKSRC     = 4'd8,
        ST_CLKSRC_WT  = 4'd9,
        ST_DIV        = 4'd10,
        ST_TRIG       = 4'd11,
        ST_CLK_EN     = 4'd12,
        ST_BUS        = 4'd13,
        ST_PERIPH     = 4'd14,
        ST_L2         = 4'd15
    } seq_state_t;

endpackage

// File: rtl/pwrseq_timer.sv
// Module: pwrseq_timer
// Down-counter for the timed waits. Loading sets a new count. While tick is
// high the count falls until it reaches zero, and expired is high at zero.
// Assumes load and tick are never high in the same cycle.
module pwrseq_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    // Count register: reload on request, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (tick && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/pwrseq_status.sv
// Module: pwrseq_status
// Remembered power state, one bit per cluster. Cluster 0 comes out of reset
// on and the others off. A bit is only ever set, never cleared.
// Assumes set_idx is a valid cluster index whenever set_en is high.
module pwrseq_status #(
    parameter int N_CLUS = 4,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_en,
    input  logic [IDX_W-1:0]  set_idx,
    output logic [N_CLUS-1:0] on_vec
);

    for (genvar gi = 0; gi < N_CLUS; gi++) begin : g_bit
        if (gi == 0) begin : g_always_on
            assign on_vec[gi] = 1'b1;
        end else begin : g_tracked
            logic on_q;
            // Status bit: cleared by reset, set when this cluster is accepted.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    on_q <= 1'b0;
                end else if (set_en && (set_idx == IDX_W'(gi))) begin
                    on_q <= 1'b1;
                end
            end
            assign on_vec[gi] = on_q;
        end
    end

endmodule

// File: rtl/pwrseq_bank.sv
// Module: pwrseq_bank
// Control outputs of one cluster. When sel is high, the bank decodes the
// sequencer state and moves the matching control bit at the next edge.
// With ALWAYS_ON set, the bank ties off to the running values.
// Assumes the sequencer visits the states in their enum order.
module pwrseq_bank
    import pwrseq_pkg::*;
#(
    parameter bit ALWAYS_ON = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel,
    input  seq_state_t state,
    output logic       rst_rel,
    output logic       clus_io_iso,
    output logic       dft_iso,
    output logic       mem_iso,
    output logic       core_io_iso,
    output logic       core_mem_iso,
    output logic       pll_ldo_en,
    output logic       pll_en,
    output logic       pll_out_iso,
    output logic       clksrc_rst_rel,
    output logic       div_load,
    output logic       clk_trig,
    output logic       func_clk_en,
    output logic       bus_rst_rel,
    output logic       periph_rst_rel,
    output logic       l2_rst_rel
);

    if (ALWAYS_ON) begin : g_running
        assign rst_rel        = 1'b1;
        assign clus_io_iso    = 1'b0;
        assign dft_iso        = 1'b1;
        assign mem_iso        = 1'b1;
        assign core_io_iso    = 1'b0;
        assign core_mem_iso   = 1'b1;
        assign pll_ldo_en     = 1'b1;
        assign pll_en         = 1'b1;
        assign pll_out_iso    = 1'b0;
        assign clksrc_rst_rel = 1'b1;
        assign div_load       = 1'b0;
        assign clk_trig       = 1'b0;
        assign func_clk_en    = 1'b1;
        assign bus_rst_rel    = 1'b1;
        assign periph_rst_rel = 1'b1;
        assign l2_rst_rel     = 1'b1;
        logic unused_in;
        assign unused_in = &{1'b0, clk, rst_n, sel, state};
    end else begin : g_switched
        logic rst_q, cio_q, dft_q, mem_q, kio_q, kmem_q;
        logic ldo_q, pll_q, oiso_q, src_q, div_q, trg_q;
        logic fclk_q, bus_q, per_q, l2_q;

        // Step decode: each state of the selected cluster moves its own bits.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rst_q  <= 1'b0;
                cio_q  <= 1'b1;
                dft_q  <= 1'b0;
                mem_q  <= 1'b0;
                kio_q  <= 1'b1;
                kmem_q <= 1'b0;
                ldo_q  <= 1'b0;
                pll_q  <= 1'b0;
                oiso_q <= 1'b0;
                src_q  <= 1'b0;
                div_q  <= 1'b0;
                trg_q  <= 1'b0;
                fclk_q <= 1'b0;
                bus_q  <= 1'b0;
                per_q  <= 1'b0;
                l2_q   <= 1'b0;
            end else begin
                div_q <= 1'b0;
                trg_q <= 1'b0;
                if (sel) begin
                    unique case (state)
                        ST_RST:       rst_q <= 1'b1;
                        ST_ISO_CLUS: begin
                            cio_q <= 1'b0;
                            dft_q <= 1'b1;
                            mem_q <= 1'b1;
                        end
                        ST_ISO_CORE: begin
                            kio_q  <= 1'b0;
                            kmem_q <= 1'b1;
                        end
                        ST_PLL_ON: begin
                            ldo_q  <= 1'b1;
                            pll_q  <= 1'b1;
                            oiso_q <= 1'b1;
                        end
                        ST_PLL_DEISO: oiso_q <= 1'b0;
                        ST_CLKSRC:    src_q  <= 1'b1;
                        ST_DIV:       div_q  <= 1'b1;
                        ST_TRIG:      trg_q  <= 1'b1;
                        ST_CLK_EN:    fclk_q <= 1'b1;
                        ST_BUS:       bus_q  <= 1'b1;
                        ST_PERIPH:    per_q  <= 1'b1;
                        ST_L2:        l2_q   <= 1'b1;
                        default: ;
                    endcase
                end
            end
        end

        assign rst_rel        = rst_q;
        assign clus_io_iso    = cio_q;
        assign dft_iso        = dft_q;
        assign mem_iso        = mem_q;
        assign core_io_iso    = kio_q;
        assign core_mem_iso   = kmem_q;
        assign pll_ldo_en     = ldo_q;
        assign pll_en         = pll_q;
        assign pll_out_iso    = oiso_q;
        assign clksrc_rst_rel = src_q;
        assign div_load       = div_q;
        assign clk_trig       = trg_q;
        assign func_clk_en    = fclk_q;
        assign bus_rst_rel    = bus_q;
        assign periph_rst_rel = per_q;
        assign l2_rst_rel     = l2_q;

        // R7: L2 reset only leaves reset after bus and peripheral resets.
        assert_l2_after_periph_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(l2_q) |-> (per_q && bus_q));
        // R7: peripheral reset only after the bus resets.
        assert_periph_after_bus_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(per_q) |-> (bus_q && fclk_q));
        // R6: the trigger follows a divider load in the previous cycle.
        assert_trig_after_div_R6: assert property (@(posedge clk) disable iff (!rst_n)
            trg_q |-> $past(div_q));
        // R4: dropping PLL output isolation keeps both power enables on.
        assert_deiso_keeps_power_R4: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(oiso_q) |-> (ldo_q && pll_q));
    end

endmodule

// File: rtl/clus_pwr_seq.sv
// Module: clus_pwr_seq
// Top of the cluster power-up sequencer. It accepts one request at a time,
// walks the fixed step order for the addressed cluster and uses a shared
// timer for the microsecond waits.
// Assumes CYC_PER_US >= 1 and that N_CLUS fits in IDX_W bits.
module clus_pwr_seq
    import pwrseq_pkg::*;
#(
    parameter int N_CLUS      = 4,
    parameter int IDX_W       = 3,
    parameter int CYC_PER_US  = 125,
    parameter int PLL_WAIT_US = 2,
    parameter int CLK_WAIT_US = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [IDX_W-1:0]  req_idx,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [N_CLUS-1:0] clus_on,
    output logic [N_CLUS-1:0] rst_rel,
    output logic [N_CLUS-1:0] clus_io_iso,
    output logic [N_CLUS-1:0] dft_iso,
    output logic [N_CLUS-1:0] mem_iso,
    output logic [N_CLUS-1:0] core_io_iso,
    output logic [N_CLUS-1:0] core_mem_iso,
    output logic [N_CLUS-1:0] pll_ldo_en,
    output logic [N_CLUS-1:0] pll_en,
    output logic [N_CLUS-1:0] pll_out_iso,
    output logic [N_CLUS-1:0] clksrc_rst_rel,
    output logic [N_CLUS-1:0] div_load,
    output logic [N_CLUS-1:0] clk_trig,
    output logic [N_CLUS-1:0] func_clk_en,
    output logic [N_CLUS-1:0] bus_rst_rel,
    output logic [N_CLUS-1:0] periph_rst_rel,
    output logic [N_CLUS-1:0] l2_rst_rel
);

    localparam int LONG_CYC  = PLL_WAIT_US * CYC_PER_US;
    localparam int SHORT_CYC = CLK_WAIT_US * CYC_PER_US;
    localparam int CNT_W     = $clog2(LONG_CYC + 1);
    localparam logic [CNT_W-1:0] LONG_LD  = CNT_W'(LONG_CYC - 1);
    localparam logic [CNT_W-1:0] SHORT_LD = CNT_W'(SHORT_CYC - 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_CLUS - 1);

    seq_state_t       state_q;
    logic [IDX_W-1:0] act_q;
    logic             busy_q, done_q, err_q;
    logic             idx_ok, idx_on, accept;
    logic             tmr_load, tmr_tick, tmr_exp;
    logic [CNT_W-1:0] tmr_val;

    // Request check: index in range and not cluster 0.
    assign idx_ok = (req_idx != '0) && (req_idx <= LAST_IDX);

    // Look up the remembered state of the requested cluster.
    always_comb begin
        idx_on = 1'b0;
        for (int i = 0; i < N_CLUS; i++) begin
            if (req_idx == IDX_W'(i)) idx_on = clus_on[i];
        end
    end

    assign accept = (state_q == ST_IDLE) && req_valid && idx_ok && !idx_on;

    // Timer control: load in the step before each wait, count during waits.
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = SHORT_LD;
        unique case (state_q)
            ST_PLL_ON: begin
                tmr_load = 1'b1;
                tmr_val  = LONG_LD;
            end
            ST_PLL_DEISO, ST_CLKSRC: tmr_load = 1'b1;
            default: ;
        endcase
    end
    assign tmr_tick = (state_q == ST_PLL_WAIT) || (state_q == ST_CFG_WAIT)
                   || (state_q == ST_CLKSRC_WT);

    // Sequencer: step order, request handling and completion flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            act_q   <= '0;
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        if (!idx_ok) begin
                            done_q <= 1'b1;
                            err_q  <= 1'b1;
                        end else if (idx_on) begin
                            done_q <= 1'b1;
                        end else begin
                            act_q   <= req_idx;
                            busy_q  <= 1'b1;
                            state_q <= ST_RST;
                        end
                    end
                end
                ST_PLL_WAIT:  if (tmr_exp) state_q <= ST_PLL_DEISO;
                ST_CFG_WAIT:  if (tmr_exp) state_q <= ST_CLKSRC;
                ST_CLKSRC_WT: if (tmr_exp) state_q <= ST_DIV;
                ST_L2: begin
                    done_q  <= 1'b1;
                    busy_q  <= 1'b0;
                    state_q <= ST_IDLE;
                end
                default: state_q <= seq_state_t'(state_q + 4'd1);
            endcase
        end
    end

    assign busy = busy_q;
    assign done = done_q;
    assign err  = err_q;

    pwrseq_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .tick     (tmr_tick),
        .expired  (tmr_exp)
    );

    pwrseq_status #(.N_CLUS(N_CLUS), .IDX_W(IDX_W)) u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (accept),
        .set_idx (req_idx),
        .on_vec  (clus_on)
    );

    for (genvar gc = 0; gc < N_CLUS; gc++) begin : g_bank
        pwrseq_bank #(.ALWAYS_ON(gc == 0)) u_bank (
            .clk            (clk),
            .rst_n          (rst_n),
            .sel            (act_q == IDX_W'(gc)),
            .state          (state_q),
            .rst_rel        (rst_rel[gc]),
            .clus_io_iso    (clus_io_iso[gc]),
            .dft_iso        (dft_iso[gc]),
            .mem_iso        (mem_iso[gc]),
            .core_io_iso    (core_io_iso[gc]),
            .core_mem_iso   (core_mem_iso[gc]),
            .pll_ldo_en     (pll_ldo_en[gc]),
            .pll_en         (pll_en[gc]),
            .pll_out_iso    (pll_out_iso[gc]),
            .clksrc_rst_rel (clksrc_rst_rel[gc]),
            .div_load       (div_load[gc]),
            .clk_trig       (clk_trig[gc]),
            .func_clk_en    (func_clk_en[gc]),
            .bus_rst_rel    (bus_rst_rel[gc]),
            .periph_rst_rel (periph_rst_rel[gc]),
            .l2_rst_rel     (l2_rst_rel[gc])
        );
    end

    // R8: busy and done are never high together.
    assert_busy_done_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));
    // R11: an error is always reported together with done.
    assert_err_with_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);
    // R4: the PLL wait is not left before the timer expires.
    assert_pll_wait_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PLL_WAIT && !tmr_exp) |=> (state_q == ST_PLL_WAIT));
    // R2: an accepted request turns exactly one more cluster on.
    assert_accept_marks_on_R2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> ($countones(clus_on) == $past($countones(clus_on)) + 1));
    // R6: at most one cluster sees a divider load or trigger at a time.
    assert_pulse_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(div_load) && $onehot0(clk_trig));

endmodule

// File: tb/clus_pwr_seq_test.sv
module clus_pwr_seq_test;

    localparam int N  = 4;
    localparam int IW = 3;
    localparam int C  = 125;
    localparam int KL = 12 + 4 * C;
    localparam logic [15:0] OFF_VIEW = 16'h0012;
    localparam logic [15:0] RUN_VIEW = 16'hF2ED;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [IW-1:0] req_idx = '0;
    logic          busy, done, err;
    logic [N-1:0]  clus_on, rst_rel, clus_io_iso, dft_iso, mem_iso;
    logic [N-1:0]  core_io_iso, core_mem_iso, pll_ldo_en, pll_en, pll_out_iso;
    logic [N-1:0]  clksrc_rst_rel, div_load, clk_trig, func_clk_en;
    logic [N-1:0]  bus_rst_rel, periph_rst_rel, l2_rst_rel;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    clus_pwr_seq #(.N_CLUS(N), .IDX_W(IW), .CYC_PER_US(C)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_idx(req_idx),
        .busy(busy), .done(done), .err(err), .clus_on(clus_on),
        .rst_rel(rst_rel), .clus_io_iso(clus_io_iso), .dft_iso(dft_iso),
        .mem_iso(mem_iso), .core_io_iso(core_io_iso), .core_mem_iso(core_mem_iso),
        .pll_ldo_en(pll_ldo_en), .pll_en(pll_en), .pll_out_iso(pll_out_iso),
        .clksrc_rst_rel(clksrc_rst_rel), .div_load(div_load), .clk_trig(clk_trig),
        .func_clk_en(func_clk_en), .bus_rst_rel(bus_rst_rel),
        .periph_rst_rel(periph_rst_rel), .l2_rst_rel(l2_rst_rel)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // bit b of the view: 0 rst_rel,1 clus_io_iso,2 dft,3 mem,4 core_io,5 core_mem,
    // 6 ldo,7 pll_en,8 out_iso,9 clksrc,10 div,11 trig,12 fclk,13 bus,14 periph,15 l2
    function automatic logic [15:0] view(input int c);
        return {l2_rst_rel[c], periph_rst_rel[c], bus_rst_rel[c], func_clk_en[c],
                clk_trig[c], div_load[c], clksrc_rst_rel[c], pll_out_iso[c],
                pll_en[c], pll_ldo_en[c], core_mem_iso[c], core_io_iso[c],
                mem_iso[c], dft_iso[c], clus_io_iso[c], rst_rel[c]};
    endfunction

    function automatic string req_of(input int b);
        if (b == 0 || b == 1 || b == 2 || b == 3 || b == 4 || b == 5) return "R3";
        if (b == 6 || b == 7 || b == 8) return "R4";
        if (b == 9) return "R5";
        if (b == 10 || b == 11 || b == 12) return "R6";
        return "R7";
    endfunction

    function automatic int exp_first(input int b);
        case (b)
            0: return 1;
            1, 2, 3: return 2;
            4, 5: return 3;
            6, 7, 8: return 4;
            9: return 6 + 3 * C;
            10: return 7 + 4 * C;
            11: return 8 + 4 * C;
            12: return 9 + 4 * C;
            13: return 10 + 4 * C;
            14: return 11 + 4 * C;
            default: return 12 + 4 * C;
        endcase
    endfunction

    function automatic int exp_second(input int b);
        if (b == 8) return 5 + 2 * C;
        if (b == 10) return 8 + 4 * C;
        if (b == 11) return 9 + 4 * C;
        return -1;
    endfunction

    // R1: reset values of status, flags and every cluster's outputs.
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(clus_on == 4'b0001, "R1 clus_on", int'(clus_on), 1);
        chk(!busy && !done && !err, "R1 flags", int'({busy, done, err}), 0);
        chk(view(0) == RUN_VIEW, "R1 cluster0", int'(view(0)), int'(RUN_VIEW));
        for (int c = 1; c < N; c++)
            chk(view(c) == OFF_VIEW, "R1 off cluster", int'(view(c)), int'(OFF_VIEW));
    endtask

    // R2..R9, R12: full sequence with edge times, optional intruding request.
    task automatic t_sequence(input int c, input int intr);
        logic [15:0] prev, v;
        logic [15:0] others [N];
        logic [N-1:0] on_before;
        int first [16];
        int second [16];
        int n_done = 0, t_done = -1, busy_bad = 0, extra = 0;
        for (int b = 0; b < 16; b++) begin
            first[b] = -1;
            second[b] = -1;
        end
        for (int o = 0; o < N; o++) others[o] = view(o);
        on_before = clus_on;
        req_valid = 1'b1;
        req_idx = IW'(c);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy == 1'b1, "R2 busy at k=0", int'(busy), 1);
        chk(clus_on[c] == 1'b1, "R2 status at k=0", int'(clus_on[c]), 1);
        prev = view(c);
        chk(prev == OFF_VIEW, "R2 outputs at k=0", int'(prev), int'(OFF_VIEW));
        for (int k = 1; k <= KL + 3; k++) begin
            if (intr >= 0 && k == 20) begin
                req_valid = 1'b1;
                req_idx = IW'(intr);
            end else begin
                req_valid = 1'b0;
            end
            @(negedge clk);
            v = view(c);
            for (int b = 0; b < 16; b++) begin
                if (v[b] != prev[b]) begin
                    if (first[b] < 0) first[b] = k;
                    else if (second[b] < 0) second[b] = k;
                    else extra++;
                end
            end
            prev = v;
            if (done) begin
                n_done++;
                t_done = k;
            end
            if (busy != (k < KL)) busy_bad++;
        end
        for (int b = 0; b < 16; b++) begin
            chk(first[b] == exp_first(b), req_of(b), first[b], exp_first(b));
            chk(second[b] == exp_second(b), req_of(b), second[b], exp_second(b));
        end
        chk(extra == 0, "R6 extra toggles", extra, 0);
        chk(prev == RUN_VIEW, "R7 final outputs", int'(prev), int'(RUN_VIEW));
        chk(n_done == 1 && t_done == KL, "R8 done time", t_done, KL);
        chk(busy_bad == 0, "R8 busy profile", busy_bad, 0);
        for (int o = 0; o < N; o++) begin
            if (o != c) begin
                chk(view(o) == others[o], "R12 other cluster", int'(view(o)), int'(others[o]));
                chk(clus_on[o] == on_before[o], "R9 status of others",
                    int'(clus_on[o]), int'(on_before[o]));
            end
        end
    endtask

    // R10 / R11: request that completes at once, with or without error.
    task automatic t_quick(input int c, input bit exp_err, input string req);
        logic [15:0] snap [N];
        logic [N-1:0] on_before;
        for (int o = 0; o < N; o++) snap[o] = view(o);
        on_before = clus_on;
        req_valid = 1'b1;
        req_idx = IW'(c);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(done == 1'b1, req, int'(done), 1);
        chk(err == exp_err, req, int'(err), int'(exp_err));
        chk(busy == 1'b0, req, int'(busy), 0);
        @(negedge clk);
        chk(!done && !err && !busy, req, int'({busy, done, err}), 0);
        chk(clus_on == on_before, req, int'(clus_on), int'(on_before));
        for (int o = 0; o < N; o++)
            chk(view(o) == snap[o], req, int'(view(o)), int'(snap[o]));
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        t_reset();
        t_sequence(1, 2);
        chk(clus_on == 4'b0011, "R9 intruder ignored", int'(clus_on), 3);
        t_quick(1, 1'b0, "R10 repeat request");
        t_quick(0, 1'b1, "R11 index 0");
        t_quick(5, 1'b1, "R11 index 5");
        t_sequence(3, -1);
        chk(clus_on == 4'b1011, "R2 status after cluster 3", int'(clus_on), 11);
        t_sequence(2, 1);
        chk(clus_on == 4'b1111, "R2 status after cluster 2", int'(clus_on), 15);
        t_quick(3, 1'b0, "R10 repeat request cluster 3");
        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            summary();
            $finish;
        end
    end

endmodule